// File: doc/BRIEF.md
# Channel Command Stream Decoder

This block sits behind the fetch stage of a host-side command channel. It takes one 32-bit command word per cycle through a valid/ready input and classifies each word as either an opcode or a payload word belonging to the opcode before it. The decoder tracks how many payload words are still owed, which register offset the next word goes to, and which hardware class is selected.

Register writes leave as single-cycle records that carry class, register offset and data. Gather requests, restart jumps, lock acquire/release events and unrecognised extended sub-operations each have their own pulse output with their decoded fields. The decoder never stalls, so `in_ready` is held high. Every output pulse appears on the clock edge that accepts the word causing it. Fetching gather memory, carrying out register writes and arbitrating locks are left to the blocks downstream.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After a synchronous active-low reset, all pulse outputs are low, `in_ready` is high, the current class is 0 and the next accepted word is decoded as an opcode. This also holds when reset arrives in the middle of a payload.
- R2: The opcode is bits 31:28. Set-class is 0, incrementing write 1, fixed-offset write 2, masked write 3, immediate 4, restart 5, gather 6 and extend 14. Every other opcode value is consumed with no payload word and no output pulse.
- R3: Set-class (0) loads the class from bits 15:6, and that class stays in force until the next set-class. The 6-bit mask in bits 5:0 selects popcount(mask) payload words. These are written to the offset in bits 27:16 plus the index of each set bit, taken from the lowest set bit upward. A zero mask takes no payload.
- R4: An incrementing write (1) takes the number of payload words in bits 15:0. Its first word goes to the offset in bits 27:16, and each following word goes to the previous offset plus one, wrapping modulo 4096.
- R5: A fixed-offset write (2) takes the number of payload words in bits 15:0 and sends every one of them to the offset in bits 27:16.
- R6: A masked write (3) takes popcount of the 16-bit mask in bits 15:0 payload words. They go to the offset in bits 27:16 plus the set-bit index, lowest bit first.
- R7: An immediate (4) emits one write to the offset in bits 27:16, with bits 15:0 zero-extended as data. It takes no payload word.
- R8: A restart (5) pulses `restart_valid` with the command word shifted left by 4 and truncated to 32 bits. It takes no payload word.
- R9: A gather (6) takes exactly one following word as the base address. On that word it pulses `gather_valid` with the offset (27:16), insert flag (bit 15), type flag (bit 14), count (13:0) and the address.
- R10: An extend (14) reads a sub-opcode from bits 27:24 and a lock index from bits 7:0. Sub-opcode 0 pulses `lock_valid` with `lock_release` low, and sub-opcode 1 pulses it with `lock_release` high. Any other sub-opcode pulses `ext_unknown` only.
- R11: A payload word is never decoded as an opcode, whatever its contents. Each accepted word raises at most one pulse output, in the cycle after it is accepted, and no pulse appears without an accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command word present |
| in_data | input | 32 | Command or payload word |
| in_ready | output | 1 | Always high; decoder accepts every word |
| wr_valid | output | 1 | Register write record pulse |
| wr_class | output | 10 | Class of the write |
| wr_offset | output | 12 | Register offset of the write |
| wr_data | output | 32 | Write data |
| gather_valid | output | 1 | Gather request pulse |
| gather_offset | output | 12 | Gather register offset |
| gather_insert | output | 1 | Gather insert flag |
| gather_type | output | 1 | Gather type flag |
| gather_count | output | 14 | Gather word count |
| gather_addr | output | 32 | Gather base address |
| restart_valid | output | 1 | Restart jump pulse |
| restart_addr | output | 32 | New fetch address |
| lock_valid | output | 1 | Lock event pulse |
| lock_release | output | 1 | 1 for release, 0 for acquire |
| lock_index | output | 8 | Lock index |
| ext_unknown | output | 1 | Extend with unrecognised sub-opcode |

## Verification
The assertions read the decoder's count of outstanding payload words to decide whether an accepted word was an opcode. They assume that `in_valid` is low while reset is held, so that nothing is accepted across the reset boundary. The bench keeps `in_valid` low during every reset. It also drives each word for exactly one accepted cycle and checks the outputs that edge produces before it presents the next word, so every pulse can be traced to a single word. Payload words are chosen to look like restart, extend and other opcodes, so that a decoder which mistook them for commands would raise a visible pulse.

// File: rtl/cmdq_pkg.sv
// Package: field geometry, opcode codes and the decoded-command record
// shared by the command stream decoder and its helpers.
package cmdq_pkg;

    localparam int WORD_W    = 32;
    localparam int OPC_W     = 4;
    localparam int OPC_LSB   = 28;
    localparam int OFF_W     = 12;
    localparam int OFF_LSB   = 16;
    localparam int CLS_W     = 10;
    localparam int CLS_LSB   = 6;
    localparam int SCMASK_W  = 6;
    localparam int CNT_W     = 16;
    localparam int MMASK_W   = 16;
    localparam int GCNT_W    = 14;
    localparam int GINS_BIT  = 15;
    localparam int GTYP_BIT  = 14;
    localparam int SUB_W     = 4;
    localparam int SUB_LSB   = 24;
    localparam int LOCK_W    = 8;
    localparam int JUMP_SHL  = 4;
    localparam int BIDX_W    = $clog2(MMASK_W);
    localparam int PCNT_W    = $clog2(MMASK_W + 1);

    localparam logic [OPC_W-1:0] OP_SETCLS = 4'h0;
    localparam logic [OPC_W-1:0] OP_INCW   = 4'h1;
    localparam logic [OPC_W-1:0] OP_FIXW   = 4'h2;
    localparam logic [OPC_W-1:0] OP_MSKW   = 4'h3;
    localparam logic [OPC_W-1:0] OP_IMM    = 4'h4;
    localparam logic [OPC_W-1:0] OP_JUMP   = 4'h5;
    localparam logic [OPC_W-1:0] OP_GATH   = 4'h6;
    localparam logic [OPC_W-1:0] OP_EXT    = 4'hE;

    localparam logic [SUB_W-1:0] SUB_TAKE  = 4'h0;
    localparam logic [SUB_W-1:0] SUB_DROP  = 4'h1;

    // How outstanding payload words are routed
    typedef enum logic [1:0] {
        PM_STEP = 2'd0,
        PM_HOLD = 2'd1,
        PM_BITS = 2'd2,
        PM_ADDR = 2'd3
    } paymode_e;

    // Fields of one command word, already split apart
    typedef struct packed {
        logic [OPC_W-1:0]   opc;
        logic [OFF_W-1:0]   offset;
        logic [CLS_W-1:0]   cls;
        logic [MMASK_W-1:0] walk_mask;
        logic [CNT_W-1:0]   pay_cnt;
        logic               g_insert;
        logic               g_type;
        logic [GCNT_W-1:0]  g_count;
        logic [SUB_W-1:0]   sub;
        logic [LOCK_W-1:0]  lock_idx;
    } cmd_fields_t;

endpackage

// File: rtl/cmd_popcount.sv
// Module: cmd_popcount
// Counts the set bits of a W-bit vector, purely combinational.
// Assumes W is at least 1; the result width is derived from W.
module cmd_popcount #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] ones
);
    // Sum the bits one at a time
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/cmd_lowbit.sv
// Module: cmd_lowbit
// Finds the index of the lowest set bit of a W-bit vector.
// Assumes the caller ignores idx when found is low.
module cmd_lowbit #(
    parameter int W = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    logic [W-1:0] below_any;

    // below_any[i]: some bit under position i is set
    assign below_any[0] = 1'b0;
    for (genvar g = 1; g < W; g++) begin : g_chain
        assign below_any[g] = below_any[g-1] | vec[g-1];
    end

    // Pick the single position that is set with nothing set beneath it
    always_comb begin
        idx   = '0;
        found = |vec;
        for (int i = 0; i < W; i++) begin
            if (vec[i] && !below_any[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cmd_field_split.sv
// Module: cmd_field_split
// Splits a command word into its fields and works out how many payload
// words follow it. Assumes the word is an opcode; the result is unused
// when the word is payload.
module cmd_field_split
    import cmdq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_fields_t       f
);
    logic [MMASK_W-1:0] sel_mask;
    logic [PCNT_W-1:0]  sel_ones;

    // Choose the mask to walk: six bits for set-class, sixteen otherwise
    always_comb begin
        if (word[OPC_LSB +: OPC_W] == OP_SETCLS) begin
            sel_mask = MMASK_W'(word[SCMASK_W-1:0]);
        end else begin
            sel_mask = word[MMASK_W-1:0];
        end
    end

    cmd_popcount #(.W(MMASK_W)) i_ones (
        .vec  (sel_mask),
        .ones (sel_ones)
    );

    // Extract fixed-position fields and the opcode-dependent payload length
    always_comb begin
        f.opc       = word[OPC_LSB +: OPC_W];
        f.offset    = word[OFF_LSB +: OFF_W];
        f.cls       = word[CLS_LSB +: CLS_W];
        f.walk_mask = sel_mask;
        f.g_insert  = word[GINS_BIT];
        f.g_type    = word[GTYP_BIT];
        f.g_count   = word[GCNT_W-1:0];
        f.sub       = word[SUB_LSB +: SUB_W];
        f.lock_idx  = word[LOCK_W-1:0];
        case (f.opc)
            OP_SETCLS, OP_MSKW: f.pay_cnt = CNT_W'(sel_ones);
            OP_INCW, OP_FIXW:   f.pay_cnt = word[CNT_W-1:0];
            OP_GATH:            f.pay_cnt = CNT_W'(1);
            default:            f.pay_cnt = '0;
        endcase
    end
endmodule

// File: rtl/cmd_stream_decoder.sv
// Module: cmd_stream_decoder
// Decodes a stream of 32-bit channel command words into register write
// records and gather, restart and lock events. Accepts one word per cycle
// and never stalls. Every output is registered and pulses for one cycle on
// the edge that accepts the word causing it.
module cmd_stream_decoder
    import cmdq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              in_ready,
    output logic              wr_valid,
    output logic [9:0]        wr_class,
    output logic [11:0]       wr_offset,
    output logic [31:0]       wr_data,
    output logic              gather_valid,
    output logic [11:0]       gather_offset,
    output logic              gather_insert,
    output logic              gather_type,
    output logic [13:0]       gather_count,
    output logic [31:0]       gather_addr,
    output logic              restart_valid,
    output logic [31:0]       restart_addr,
    output logic              lock_valid,
    output logic              lock_release,
    output logic [7:0]        lock_index,
    output logic              ext_unknown
);
    cmd_fields_t         dec;
    logic [CNT_W-1:0]    pay_left;
    paymode_e            pay_mode;
    logic [OFF_W-1:0]    cur_off;
    logic [MMASK_W-1:0]  mask_left;
    logic [CLS_W-1:0]    cur_cls;
    logic [OFF_W-1:0]    hold_goff;
    logic                hold_gins;
    logic                hold_gtyp;
    logic [GCNT_W-1:0]   hold_gcnt;
    logic [BIDX_W-1:0]   bit_idx;
    logic                bit_found;
    logic                accept;
    logic                at_opcode;

    // The decoder never back-pressures
    assign in_ready  = 1'b1;
    assign accept    = in_valid && in_ready;
    assign at_opcode = (pay_left == '0);

    cmd_field_split i_split (
        .word (in_data),
        .f    (dec)
    );

    cmd_lowbit #(.W(MMASK_W)) i_low (
        .vec   (mask_left),
        .idx   (bit_idx),
        .found (bit_found)
    );

    // Payload bookkeeping and class state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_left  <= '0;
            pay_mode  <= PM_STEP;
            cur_off   <= '0;
            mask_left <= '0;
            cur_cls   <= '0;
            hold_goff <= '0;
            hold_gins <= 1'b0;
            hold_gtyp <= 1'b0;
            hold_gcnt <= '0;
        end else if (accept) begin
            if (at_opcode) begin
                pay_left <= dec.pay_cnt;
                cur_off  <= dec.offset;
                case (dec.opc)
                    OP_SETCLS: begin
                        cur_cls   <= dec.cls;
                        pay_mode  <= PM_BITS;
                        mask_left <= dec.walk_mask;
                    end
                    OP_INCW:   pay_mode <= PM_STEP;
                    OP_FIXW:   pay_mode <= PM_HOLD;
                    OP_MSKW: begin
                        pay_mode  <= PM_BITS;
                        mask_left <= dec.walk_mask;
                    end
                    OP_GATH: begin
                        pay_mode  <= PM_ADDR;
                        hold_goff <= dec.offset;
                        hold_gins <= dec.g_insert;
                        hold_gtyp <= dec.g_type;
                        hold_gcnt <= dec.g_count;
                    end
                    default: pay_mode <= pay_mode;
                endcase
            end else begin
                pay_left <= pay_left - CNT_W'(1);
                case (pay_mode)
                    PM_STEP: cur_off   <= cur_off + OFF_W'(1);
                    PM_BITS: mask_left <= mask_left & (mask_left - MMASK_W'(1));
                    default: cur_off   <= cur_off;
                endcase
            end
        end
    end

    // Register write records
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid  <= 1'b0;
            wr_class  <= '0;
            wr_offset <= '0;
            wr_data   <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (accept && at_opcode && dec.opc == OP_IMM) begin
                wr_valid  <= 1'b1;
                wr_class  <= cur_cls;
                wr_offset <= dec.offset;
                wr_data   <= WORD_W'(in_data[CNT_W-1:0]);
            end else if (accept && !at_opcode && pay_mode != PM_ADDR) begin
                wr_valid <= 1'b1;
                wr_class <= cur_cls;
                wr_data  <= in_data;
                if (pay_mode == PM_BITS && bit_found) begin
                    wr_offset <= cur_off + OFF_W'(bit_idx);
                end else begin
                    wr_offset <= cur_off;
                end
            end
        end
    end

    // Gather request on its address word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gather_valid  <= 1'b0;
            gather_offset <= '0;
            gather_insert <= 1'b0;
            gather_type   <= 1'b0;
            gather_count  <= '0;
            gather_addr   <= '0;
        end else begin
            gather_valid <= 1'b0;
            if (accept && !at_opcode && pay_mode == PM_ADDR) begin
                gather_valid  <= 1'b1;
                gather_offset <= hold_goff;
                gather_insert <= hold_gins;
                gather_type   <= hold_gtyp;
                gather_count  <= hold_gcnt;
                gather_addr   <= in_data;
            end
        end
    end

    // Restart jumps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_valid <= 1'b0;
            restart_addr  <= '0;
        end else begin
            restart_valid <= 1'b0;
            if (accept && at_opcode && dec.opc == OP_JUMP) begin
                restart_valid <= 1'b1;
                restart_addr  <= in_data << JUMP_SHL;
            end
        end
    end

    // Lock events and unrecognised extend sub-opcodes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_valid   <= 1'b0;
            lock_release <= 1'b0;
            lock_index   <= '0;
            ext_unknown  <= 1'b0;
        end else begin
            lock_valid  <= 1'b0;
            ext_unknown <= 1'b0;
            if (accept && at_opcode && dec.opc == OP_EXT) begin
                if (dec.sub == SUB_TAKE || dec.sub == SUB_DROP) begin
                    lock_valid   <= 1'b1;
                    lock_release <= (dec.sub == SUB_DROP);
                    lock_index   <= dec.lock_idx;
                end else begin
                    ext_unknown <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
// Module: cmd_stream_decoder_chk
// Temporal checks on the decoder's pulse outputs, attached by bind.
// Assumes in_valid stays low while reset is held.
module cmd_stream_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic [15:0] pay_left,
    input logic        wr_valid,
    input logic [31:0] wr_data,
    input logic [11:0] wr_offset,
    input logic        gather_valid,
    input logic        restart_valid,
    input logic [31:0] restart_addr,
    input logic        lock_valid,
    input logic        ext_unknown
);
    logic [4:0] pulses;
    assign pulses = {wr_valid, gather_valid, restart_valid, lock_valid, ext_unknown};

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pulses == 5'b0);

    // R11
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));

    // R11
    cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulses != 5'b0) |-> $past(in_valid));

    // R8
    restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(pay_left) == 16'd0
         && $past(in_data[31:28]) == 4'h5)
        |-> restart_valid && restart_addr == ($past(in_data) << 4));

    // R7
    imm_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(pay_left) == 16'd0
         && $past(in_data[31:28]) == 4'h4)
        |-> wr_valid && wr_data == {16'h0, $past(in_data[15:0])}
            && wr_offset == $past(in_data[27:16]));

    // R10
    lock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_valid || ext_unknown) |->
            ($past(in_data[31:28]) == 4'hE && $past(pay_left) == 16'd0));

    // R11
    payload_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(pay_left) != 16'd0)
        |-> !restart_valid && !lock_valid && !ext_unknown);
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .pay_left      (pay_left),
    .wr_valid      (wr_valid),
    .wr_data       (wr_data),
    .wr_offset     (wr_offset),
    .gather_valid  (gather_valid),
    .restart_valid (restart_valid),
    .restart_addr  (restart_addr),
    .lock_valid    (lock_valid),
    .ext_unknown   (ext_unknown)
);

// File: tb/test_cmd_stream_decoder.sv
// Bench: sweeps every set-class mask, a range of write counts and masks,
// every extend sub-opcode and every undefined opcode, with expected
// outputs worked out from the requirements.
module test_cmd_stream_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        wr_valid;
    logic [9:0]  wr_class;
    logic [11:0] wr_offset;
    logic [31:0] wr_data;
    logic        gather_valid;
    logic [11:0] gather_offset;
    logic        gather_insert;
    logic        gather_type;
    logic [13:0] gather_count;
    logic [31:0] gather_addr;
    logic        restart_valid;
    logic [31:0] restart_addr;
    logic        lock_valid;
    logic        lock_release;
    logic [7:0]  lock_index;
    logic        ext_unknown;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cmd_stream_decoder i_cmd_stream_decoder (.*);

    // Compare one value and log a mismatch
    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] pulses();
        return {wr_valid, gather_valid, restart_valid, lock_valid, ext_unknown};
    endfunction

    // Present one word for one accepted cycle; outputs are valid on return
    task automatic push(input logic [31:0] w);
        in_valid = 1'b1;
        in_data  = w;
        @(posedge clk);
        #2;
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n    = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    task automatic exp_quiet(input string req);
        chk(req, "no pulse", 32'(pulses()), 32'h0);
    endtask

    task automatic exp_write(input string req, input logic [9:0] cls,
                             input logic [11:0] off, input logic [31:0] d);
        chk(req, "pulse set", 32'(pulses()), 32'h10);
        chk(req, "class", 32'(wr_class), 32'(cls));
        chk(req, "offset", 32'(wr_offset), 32'(off));
        chk(req, "data", wr_data, d);
    endtask

    // Immediate probe: proves the next word is decoded and shows the class
    task automatic probe(input string req, input logic [9:0] cls);
        push({4'h4, 12'h7A5, 16'h1234});
        exp_write(req, cls, 12'h7A5, 32'h1234);
    endtask

    initial begin
        logic [9:0] cls_now;
        logic [31:0] w;
        logic [15:0] mlist [6];
        mlist = '{16'h0001, 16'h8000, 16'hFFFF, 16'hA5A5, 16'h0000, 16'h0F08};

        do_reset();
        // R1 reset state
        exp_quiet("R1");
        chk("R1", "in_ready", 32'(in_ready), 32'h1);
        probe("R1", 10'h000);

        // R3 every set-class mask, class persists, zero mask takes no payload
        for (int m = 0; m < 64; m++) begin
            cls_now = 10'((m * 37 + 5) & 10'h3FF);
            push({4'h0, 12'(12'h100 + m), cls_now, 6'(m)});
            exp_quiet("R3");
            for (int b = 0; b < 6; b++) begin
                if (m[b]) begin
                    w = 32'h5000_0000 | 32'(m << 8) | 32'(b);
                    push(w);
                    exp_write("R3", cls_now, 12'(12'h100 + m + b), w);
                end
            end
            probe("R3", cls_now);
        end

        // R4 incrementing write, counts 0..6, offset wraps past 0xFFF
        for (int n = 0; n < 7; n++) begin
            push({4'h1, 12'hFFE, 16'(n)});
            exp_quiet("R4");
            for (int i = 0; i < n; i++) begin
                w = 32'hE000_0000 | 32'(n << 8) | 32'(i);
                push(w);
                exp_write("R4", cls_now, 12'(12'hFFE + i), w);
            end
            probe("R4", cls_now);
        end

        // R5 fixed-offset write, counts 0..4
        for (int n = 0; n < 5; n++) begin
            push({4'h2, 12'h040, 16'(n)});
            exp_quiet("R5");
            for (int i = 0; i < n; i++) begin
                w = 32'h6000_0000 + 32'(i);
                push(w);
                exp_write("R5", cls_now, 12'h040, w);
            end
            probe("R5", cls_now);
        end

        // R6 masked write over several masks, lowest bit first
        foreach (mlist[k]) begin
            push({4'h3, 12'h200, mlist[k]});
            exp_quiet("R6");
            for (int b = 0; b < 16; b++) begin
                if (mlist[k][b]) begin
                    w = 32'hF000_0000 | 32'(k << 8) | 32'(b);
                    push(w);
                    exp_write("R6", cls_now, 12'(12'h200 + b), w);
                end
            end
            probe("R6", cls_now);
        end

        // R7 immediate with high data bits set; zero-extended
        push({4'h4, 12'h3C3, 16'hBEEF});
        exp_write("R7", cls_now, 12'h3C3, 32'h0000_BEEF);

        // R8 restart address is word << 4
        w = 32'h5ABC_DEF1;
        push(w);
        chk("R8", "pulse set", 32'(pulses()), 32'h04);
        chk("R8", "addr", restart_addr, 32'hABCD_EF10);
        probe("R8", cls_now);

        // R9 gather takes exactly one address word
        push({4'h6, 12'h345, 1'b1, 1'b0, 14'h1ABC});
        exp_quiet("R9");
        push(32'h5EAD_BEE0);
        chk("R9", "pulse set", 32'(pulses()), 32'h08);
        chk("R9", "offset", 32'(gather_offset), 32'h345);
        chk("R9", "insert", 32'(gather_insert), 32'h1);
        chk("R9", "type", 32'(gather_type), 32'h0);
        chk("R9", "count", 32'(gather_count), 32'h1ABC);
        chk("R9", "addr", gather_addr, 32'h5EAD_BEE0);
        probe("R9", cls_now);

        // R10 every extend sub-opcode
        for (int s = 0; s < 16; s++) begin
            push({4'hE, 4'(s), 16'hFFFF, 8'(s * 9 + 3)});
            if (s < 2) begin
                chk("R10", "pulse set", 32'(pulses()), 32'h02);
                chk("R10", "release", 32'(lock_release), 32'(s));
                chk("R10", "index", 32'(lock_index), 32'(s * 9 + 3));
            end else begin
                chk("R10", "pulse set", 32'(pulses()), 32'h01);
            end
        end

        // R2 undefined opcodes consume nothing and emit nothing
        for (int op = 7; op < 16; op++) begin
            if (op != 14) begin
                push({4'(op), 28'hFFF_FFFF});
                exp_quiet("R2");
                probe("R2", cls_now);
            end
        end

        // R11 idle cycles emit nothing
        @(posedge clk);
        #2;
        exp_quiet("R11");

        // R1 reset in the middle of a payload
        push({4'h0, 12'h000, 10'h155, 6'h0});
        push({4'h1, 12'h010, 16'h0003});
        push(32'h0000_0001);
        exp_write("R1", 10'h155, 12'h010, 32'h1);
        do_reset();
        exp_quiet("R1");
        probe("R1", 10'h000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule